// File: doc/BRIEF.md
# Permission-Aware Set-Associative Tag Directory

This block is the metadata store behind a coherent cache controller. It holds no data. Each way of each set records a line address, a two-bit access permission and a lock context identifier. The controller issues one command per cycle and gets the result on the next cycle. Commands cover access checks, lookups that ignore permission, availability tests, allocation, deallocation, victim probes, recency updates, permission writes, and setting, clearing and testing the line lock.

The set index comes from the line address, starting at bit `INDEX_LSB`. It is `log2(SETS)` bits wide, with `SETS = CAP_BYTES / WAYS / LINE_BYTES`, and there must be at least two sets. A tag match alone is not a hit. The stored permission must allow the request kind. A way counts as free when it is empty or holds the not-present permission. A parameter picks the replacement state kept for each set: true LRU (`USE_PLRU=0`) or a binary-tree pseudo-LRU (`USE_PLRU=1`).

Top module: `tagdir`

## Requirements
- R1: After reset `rsp_valid_o` is 0 and every way is empty. An availability test returns ok=1, an access check returns ok=0 and a permission-blind lookup returns ok=0.
- R2: `req_ready_o` is always 1. A request sampled on a clock edge produces `rsp_valid_o`=1 after that edge, and a cycle without a request produces `rsp_valid_o`=0.
- R3: Access check (cmd 0) uses permission codes not-present=0, invalid=1, read-only=2, read-write=3 and kind codes load=0, ifetch=1, store=2, atomic=3. It returns ok=1 only on a tag match with read-write, or with read-only and kind load or ifetch. Every other case returns ok=0.
- R4: A tag match on a way that is not not-present marks that way most recently used. This applies to an access check that fails on permission and to the touch command (cmd 6), which returns ok=1 on a match.
- R5: The availability test (cmd 2) returns ok=1 when the address matches any occupied way of its set, or when the set has a free way. Otherwise it returns ok=0.
- R6: Allocate (cmd 3) picks the lowest-numbered free way and reports it on `rsp_way_o`. It writes the tag, sets permission to invalid, sets the lock to the no-owner value (all ones) and marks the way most recently used.
- R7: Allocate of an address that already hits, or into a set with no free way, returns err=1 and ok=0 and changes nothing.
- R8: Deallocate (cmd 4) of a hitting address returns ok=1 and empties its way. Deallocate of a missing address returns ok=0 and err=0.
- R9: The victim probe (cmd 5) returns on `rsp_addr_o` the line address held in the way the replacement policy selects. It returns ok=1 only when the set has no available way. With true LRU the victim is the least recently touched way.
- R10: With `USE_PLRU=1` each set keeps a WAYS-1 bit tree. A touch turns every node on the path away from the touched way, and the victim is found by following the node bits from the root.
- R11: Lock set (cmd 7) stores `req_ctx_i` and lock clear (cmd 8) stores the no-owner value. Lock test (cmd 9) returns ok=1 only when the stored context equals `req_ctx_i`. Any of the three on a missing address returns err=1.
- R12: A not-present way is hidden from the access check and the touch command, and it counts as free. The permission-blind lookup (cmd 1) and the permission write (cmd 10, which writes `req_perm_i`) still match that way by tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Command present |
| req_ready_o | output | 1 | Command accepted (always 1) |
| req_cmd_i | input | 4 | Command code |
| req_addr_i | input | ADDR_W | Line address |
| req_kind_i | input | 2 | Request kind for access check |
| req_perm_i | input | 2 | Permission for permission write |
| req_ctx_i | input | CTX_W | Lock context |
| rsp_valid_o | output | 1 | Response present |
| rsp_ok_o | output | 1 | Boolean result |
| rsp_err_o | output | 1 | Illegal command |
| rsp_way_o | output | WAY_W | Way selected or matched |
| rsp_addr_o | output | ADDR_W | Victim line address |

## Verification
The hardest cases to reach from the ports are the ones where the two policies differ, and recency updates caused by an access check that then fails on permission. The stimulus fills one set in way order, issues a store check against an invalid line, and probes. True LRU and pseudo-LRU then name different victims. The bench drives identical commands into both policy variants and compares each against hand-derived victims. Not-present lines are created with the permission write, to show that the permission-aware paths hide them while allocation reuses them.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [1:0] {
    PERM_NP  = 2'd0,
    PERM_INV = 2'd1,
    PERM_RO  = 2'd2,
    PERM_RW  = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    KIND_LOAD   = 2'd0,
    KIND_IFETCH = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_ATOMIC = 2'd3
  } kind_e;

  typedef enum logic [3:0] {
    CMD_CHECK      = 4'd0,
    CMD_LOOKUP_ANY = 4'd1,
    CMD_AVAIL      = 4'd2,
    CMD_ALLOC      = 4'd3,
    CMD_DEALLOC    = 4'd4,
    CMD_PROBE      = 4'd5,
    CMD_TOUCH      = 4'd6,
    CMD_LOCK_SET   = 4'd7,
    CMD_LOCK_CLR   = 4'd8,
    CMD_LOCK_TEST  = 4'd9,
    CMD_SET_PERM   = 4'd10
  } cmd_e;
endpackage

// File: rtl/tagdir_match.sv
module tagdir_match #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 12,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [WAYS-1:0][ADDR_W-1:0]   tags_i,
  input  logic [WAYS-1:0][1:0]          perms_i,
  input  logic [WAYS-1:0]               occ_i,
  output logic                          hit_o,
  output logic [WAY_W-1:0]              hit_way_o,
  output logic                          any_hit_o,
  output logic [WAY_W-1:0]              any_way_o,
  output logic                          free_o,
  output logic [WAY_W-1:0]              free_way_o
);
  import tagdir_pkg::*;

  logic [WAYS-1:0] tag_eq, vis_eq, is_free;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tag_eq[w]  = occ_i[w] && (tags_i[w] == addr_i);
    assign vis_eq[w]  = tag_eq[w] && (perms_i[w] != PERM_NP);
    assign is_free[w] = !occ_i[w] || (perms_i[w] == PERM_NP);
  end

  // descending scan so the lowest index wins
  always_comb begin
    hit_way_o  = '0;
    any_way_o  = '0;
    free_way_o = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (vis_eq[w])  hit_way_o  = WAY_W'(w);
      if (tag_eq[w])  any_way_o  = WAY_W'(w);
      if (is_free[w]) free_way_o = WAY_W'(w);
    end
  end

  assign hit_o     = |vis_eq;
  assign any_hit_o = |tag_eq;
  assign free_o    = |is_free;
endmodule

// File: rtl/tagdir_repl.sv
module tagdir_repl #(
  parameter int SETS     = 4,
  parameter int WAYS     = 4,
  parameter bit USE_PLRU = 1'b0,
  localparam int SET_W   = $clog2(SETS),
  localparam int WAY_W   = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] vic_way_o
);
  if (USE_PLRU) begin : g_plru
    logic [WAYS-2:0] tree_q [SETS];
    logic [WAYS-2:0] tree_nxt;

    always_comb begin
      int n;
      n = 1;
      for (int l = 0; l < WAY_W; l++) n = 2 * n + int'(tree_q[set_i][n-1]);
      vic_way_o = WAY_W'(n - WAYS);
      tree_nxt = tree_q[set_i];
      n = 1;
      for (int l = 0; l < WAY_W; l++) begin
        tree_nxt[n-1] = ~touch_way_i[WAY_W-1-l];  // point away from touched way
        n = 2 * n + int'(touch_way_i[WAY_W-1-l]);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else if (touch_i) begin
        tree_q[set_i] <= tree_nxt;
      end
    end
  end else begin : g_lru
    logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
    logic [WAY_W-1:0] age_t;

    assign age_t = age_q[set_i][touch_way_i];

    always_comb begin
      vic_way_o = '0;
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_i][w] == WAY_W'(WAYS-1)) vic_way_o = WAY_W'(w);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(WAYS-1-w);
      end else if (touch_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way_i)   age_q[set_i][w] <= '0;
          else if (age_q[set_i][w] < age_t) age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
        end
      end
    end
  end

  // R4, R9, R10: a just-touched way is never the next victim of the same set
  a_r9_touch_not_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(touch_i) && set_i == $past(set_i)) |-> vic_way_o != $past(touch_way_i));
endmodule

// File: rtl/tagdir.sv
module tagdir #(
  parameter int ADDR_W     = 12,
  parameter int CAP_BYTES  = 256,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 16,
  parameter int INDEX_LSB  = 0,
  parameter int CTX_W      = 4,
  parameter bit USE_PLRU   = 1'b0,
  localparam int SETS      = CAP_BYTES / WAYS / LINE_BYTES,
  localparam int SET_W     = $clog2(SETS),
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [3:0]        req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_kind_i,
  input  logic [1:0]        req_perm_i,
  input  logic [CTX_W-1:0]  req_ctx_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              rsp_err_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  import tagdir_pkg::*;

  localparam logic [CTX_W-1:0] NO_OWNER = '1;

  logic [WAYS-1:0][ADDR_W-1:0] tag_q  [SETS];
  logic [WAYS-1:0][1:0]        perm_q [SETS];
  logic [WAYS-1:0][CTX_W-1:0]  lock_q [SETS];
  logic [WAYS-1:0]             occ_q  [SETS];

  cmd_e             cmd;
  logic [SET_W-1:0] set_idx;
  logic             hit, any_hit, free, avail, alloc_err;
  logic [WAY_W-1:0] hit_way, any_way, free_way, vic_way;
  logic [1:0]       cur_perm;
  logic             touch_en;
  logic [WAY_W-1:0] touch_way;
  logic             ok_d, err_d;
  logic [WAY_W-1:0] way_d;
  logic [ADDR_W-1:0] addr_d;

  assign cmd         = cmd_e'(req_cmd_i);
  assign set_idx     = req_addr_i[INDEX_LSB +: SET_W];
  assign req_ready_o = 1'b1;

  tagdir_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_match (
    .addr_i    (req_addr_i),
    .tags_i    (tag_q[set_idx]),
    .perms_i   (perm_q[set_idx]),
    .occ_i     (occ_q[set_idx]),
    .hit_o     (hit),
    .hit_way_o (hit_way),
    .any_hit_o (any_hit),
    .any_way_o (any_way),
    .free_o    (free),
    .free_way_o(free_way)
  );

  tagdir_repl #(.SETS(SETS), .WAYS(WAYS), .USE_PLRU(USE_PLRU)) u_repl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_idx),
    .touch_i    (touch_en),
    .touch_way_i(touch_way),
    .vic_way_o  (vic_way)
  );

  assign cur_perm  = perm_q[set_idx][hit_way];
  assign avail     = any_hit || free;
  assign alloc_err = hit || !free;

  always_comb begin
    ok_d      = 1'b0;
    err_d     = 1'b0;
    way_d     = '0;
    addr_d    = '0;
    touch_en  = 1'b0;
    touch_way = hit_way;
    unique case (cmd)
      CMD_CHECK: begin
        ok_d     = hit && (cur_perm == PERM_RW ||
                   (cur_perm == PERM_RO && (req_kind_i == KIND_LOAD || req_kind_i == KIND_IFETCH)));
        touch_en = req_valid_i && hit;
        way_d    = hit_way;
      end
      CMD_LOOKUP_ANY, CMD_SET_PERM: begin
        ok_d  = any_hit;
        way_d = any_way;
      end
      CMD_AVAIL: ok_d = avail;
      CMD_ALLOC: begin
        err_d     = alloc_err;
        ok_d      = !alloc_err;
        way_d     = free_way;
        touch_en  = req_valid_i && !alloc_err;
        touch_way = free_way;
      end
      CMD_DEALLOC: begin
        ok_d  = hit;
        way_d = hit_way;
      end
      CMD_PROBE: begin
        ok_d   = !avail;
        way_d  = vic_way;
        addr_d = tag_q[set_idx][vic_way];
      end
      CMD_TOUCH: begin
        ok_d     = hit;
        way_d    = hit_way;
        touch_en = req_valid_i && hit;
      end
      CMD_LOCK_SET, CMD_LOCK_CLR: begin
        ok_d  = hit;
        err_d = !hit;
        way_d = hit_way;
      end
      CMD_LOCK_TEST: begin
        ok_d  = hit && (lock_q[set_idx][hit_way] == req_ctx_i);
        err_d = !hit;
        way_d = hit_way;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        perm_q[s] <= '0;
        lock_q[s] <= {WAYS{NO_OWNER}};
        occ_q[s]  <= '0;
      end
    end else if (req_valid_i) begin
      unique case (cmd)
        CMD_ALLOC: if (!alloc_err) begin
          tag_q[set_idx][free_way]  <= req_addr_i;
          perm_q[set_idx][free_way] <= PERM_INV;
          lock_q[set_idx][free_way] <= NO_OWNER;
          occ_q[set_idx][free_way]  <= 1'b1;
        end
        CMD_DEALLOC: if (hit) begin
          occ_q[set_idx][hit_way]  <= 1'b0;
          perm_q[set_idx][hit_way] <= PERM_NP;
        end
        CMD_LOCK_SET: if (hit) lock_q[set_idx][hit_way] <= req_ctx_i;
        CMD_LOCK_CLR: if (hit) lock_q[set_idx][hit_way] <= NO_OWNER;
        CMD_SET_PERM: if (any_hit) perm_q[set_idx][any_way] <= req_perm_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_ok_o    <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_way_o   <= '0;
      rsp_addr_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_ok_o    <= req_valid_i && ok_d;
      rsp_err_o   <= req_valid_i && err_d;
      rsp_way_o   <= way_d;
      rsp_addr_o  <= addr_d;
    end
  end

  a_r2_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r3_ro_store_denied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cmd == CMD_CHECK && hit && cur_perm == PERM_RO && req_kind_i == KIND_STORE)
      |=> !rsp_ok_o);
  a_r6_alloc_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cmd == CMD_ALLOC && !alloc_err) |=>
      (occ_q[$past(set_idx)][$past(free_way)] &&
       perm_q[$past(set_idx)][$past(free_way)] == PERM_INV &&
       lock_q[$past(set_idx)][$past(free_way)] == NO_OWNER));
  a_r7_dup_alloc_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cmd == CMD_ALLOC && hit) |=> (rsp_err_o && !rsp_ok_o));
  a_r8_dealloc_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cmd == CMD_DEALLOC && hit) |=> !occ_q[$past(set_idx)][$past(hit_way)]);
  a_r11_lock_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cmd == CMD_LOCK_SET && hit) |=>
      lock_q[$past(set_idx)][$past(hit_way)] == $past(req_ctx_i));
endmodule

// File: tb/tagdir_test.sv
module tagdir_test;
  localparam int ADDR_W = 12;
  localparam int CTX_W  = 4;
  localparam int WAY_W  = 2;

  localparam logic [3:0] C_CHECK = 4'd0, C_ANY = 4'd1, C_AVAIL = 4'd2, C_ALLOC = 4'd3,
                         C_DEALLOC = 4'd4, C_PROBE = 4'd5, C_TOUCH = 4'd6, C_LSET = 4'd7,
                         C_LCLR = 4'd8, C_LTEST = 4'd9, C_SPERM = 4'd10;
  localparam logic [1:0] K_LD = 2'd0, K_IF = 2'd1, K_ST = 2'd2, K_AT = 2'd3;
  localparam logic [1:0] P_NP = 2'd0, P_INV = 2'd1, P_RO = 2'd2, P_RW = 2'd3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [3:0] req_cmd_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [1:0] req_kind_i = '0, req_perm_i = '0;
  logic [CTX_W-1:0] req_ctx_i = '0;

  logic ready_l, val_l, ok_l, err_l, ready_p, val_p, ok_p, err_p;
  logic [WAY_W-1:0] way_l, way_p;
  logic [ADDR_W-1:0] addr_l, addr_p;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tagdir #(.USE_PLRU(1'b0)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(ready_l),
    .req_cmd_i(req_cmd_i), .req_addr_i(req_addr_i), .req_kind_i(req_kind_i),
    .req_perm_i(req_perm_i), .req_ctx_i(req_ctx_i), .rsp_valid_o(val_l), .rsp_ok_o(ok_l),
    .rsp_err_o(err_l), .rsp_way_o(way_l), .rsp_addr_o(addr_l));

  tagdir #(.USE_PLRU(1'b1)) uut_plru (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(ready_p),
    .req_cmd_i(req_cmd_i), .req_addr_i(req_addr_i), .req_kind_i(req_kind_i),
    .req_perm_i(req_perm_i), .req_ctx_i(req_ctx_i), .rsp_valid_o(val_p), .rsp_ok_o(ok_p),
    .rsp_err_o(err_p), .rsp_way_o(way_p), .rsp_addr_o(addr_p));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one command at a falling edge, sample the response at the next falling edge
  task automatic cmd(input logic [3:0] c, input logic [ADDR_W-1:0] a,
                     input logic [1:0] k = 2'd0, input logic [1:0] p = 2'd0,
                     input logic [CTX_W-1:0] x = '0);
    req_cmd_i = c; req_addr_i = a; req_kind_i = k; req_perm_i = p; req_ctx_i = x;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "rsp_valid after reset", val_l, 0);
    cmd(C_AVAIL, 12'h010);
    chk("R1", "avail empty", ok_l, 1);
    cmd(C_CHECK, 12'h010, K_LD);
    chk("R1", "check empty", ok_l, 0);
    cmd(C_ANY, 12'h010);
    chk("R1", "blind lookup empty", ok_l, 0);
  endtask

  task automatic t_handshake;
    chk("R2", "ready", ready_l, 1);
    cmd(C_AVAIL, 12'h010);
    chk("R2", "rsp_valid after req", val_l, 1);
    @(negedge clk_i);
    chk("R2", "rsp_valid idle", val_l, 0);
  endtask

  task automatic t_fill_and_policy;
    cmd(C_ALLOC, 12'h010); chk("R6", "alloc A way", way_l, 0); chk("R6", "alloc A ok", ok_l, 1);
    cmd(C_ALLOC, 12'h014); chk("R6", "alloc B way", way_l, 1);
    cmd(C_ALLOC, 12'h018); chk("R6", "alloc C way", way_l, 2);
    cmd(C_ALLOC, 12'h01C); chk("R6", "alloc D way", way_l, 3); chk("R6", "alloc D err", err_l, 0);
    cmd(C_LTEST, 12'h010, 0, 0, 4'hF);
    chk("R6", "lock no owner after alloc", ok_l, 1);
    cmd(C_PROBE, 12'h000);
    chk("R9", "probe full ok", ok_l, 1);
    chk("R9", "lru victim", addr_l, 12'h010);
    chk("R10", "plru victim", addr_p, 12'h010);
    cmd(C_CHECK, 12'h010, K_ST);
    chk("R6", "invalid store denied", ok_l, 0);
    cmd(C_PROBE, 12'h000);
    chk("R4", "lru victim after failed check", addr_l, 12'h014);
    chk("R10", "plru victim after failed check", addr_p, 12'h018);
  endtask

  task automatic t_avail_errors;
    cmd(C_AVAIL, 12'h020); chk("R5", "avail new full", ok_l, 0);
    cmd(C_AVAIL, 12'h014); chk("R5", "avail present", ok_l, 1);
    cmd(C_ALLOC, 12'h020); chk("R7", "full alloc err", err_l, 1); chk("R7", "full alloc ok", ok_l, 0);
    cmd(C_ALLOC, 12'h014); chk("R7", "dup alloc err", err_l, 1);
    cmd(C_ANY, 12'h020);   chk("R7", "failed alloc left no tag", ok_l, 0);
  endtask

  task automatic t_not_present;
    cmd(C_SPERM, 12'h014, 0, P_NP); chk("R12", "perm write ok", ok_l, 1); chk("R12", "perm write way", way_l, 1);
    cmd(C_CHECK, 12'h014, K_LD);  chk("R12", "np hidden from check", ok_l, 0);
    cmd(C_TOUCH, 12'h014);        chk("R12", "np hidden from touch", ok_l, 0);
    cmd(C_ANY, 12'h014);          chk("R12", "blind lookup hit", ok_l, 1); chk("R12", "blind lookup way", way_l, 1);
    cmd(C_AVAIL, 12'h020);        chk("R5", "np counts free", ok_l, 1);
    cmd(C_ALLOC, 12'h020);        chk("R6", "reuse np way", way_l, 1);
    cmd(C_ANY, 12'h014);          chk("R12", "old tag replaced", ok_l, 0);
  endtask

  task automatic t_dealloc;
    cmd(C_DEALLOC, 12'h018); chk("R8", "dealloc ok", ok_l, 1); chk("R8", "dealloc way", way_l, 2);
    cmd(C_ANY, 12'h018);     chk("R8", "gone after dealloc", ok_l, 0);
    cmd(C_ALLOC, 12'h024);   chk("R8", "freed way reused", way_l, 2);
    cmd(C_DEALLOC, 12'h0F0); chk("R8", "dealloc miss ok", ok_l, 0); chk("R8", "dealloc miss err", err_l, 0);
  endtask

  task automatic t_access_rules;
    cmd(C_ALLOC, 12'h011); chk("R6", "set1 alloc way", way_l, 0);
    cmd(C_SPERM, 12'h011, 0, P_RO);
    cmd(C_CHECK, 12'h011, K_LD); chk("R3", "ro load", ok_l, 1);
    cmd(C_CHECK, 12'h011, K_IF); chk("R3", "ro ifetch", ok_l, 1);
    cmd(C_CHECK, 12'h011, K_ST); chk("R3", "ro store", ok_l, 0);
    cmd(C_CHECK, 12'h011, K_AT); chk("R3", "ro atomic", ok_l, 0);
    cmd(C_SPERM, 12'h011, 0, P_RW);
    cmd(C_CHECK, 12'h011, K_ST); chk("R3", "rw store", ok_l, 1);
    cmd(C_CHECK, 12'h011, K_AT); chk("R3", "rw atomic", ok_l, 1);
    cmd(C_SPERM, 12'h011, 0, P_INV);
    cmd(C_CHECK, 12'h011, K_LD); chk("R3", "inv load", ok_l, 0);
    cmd(C_CHECK, 12'h031, K_LD); chk("R3", "miss load", ok_l, 0);
  endtask

  task automatic t_locks;
    cmd(C_LSET, 12'h011, 0, 0, 4'h5);  chk("R11", "lock set ok", ok_l, 1);
    cmd(C_LTEST, 12'h011, 0, 0, 4'h5); chk("R11", "test owner", ok_l, 1);
    cmd(C_LTEST, 12'h011, 0, 0, 4'h6); chk("R11", "test other", ok_l, 0);
    cmd(C_LCLR, 12'h011);
    cmd(C_LTEST, 12'h011, 0, 0, 4'h5); chk("R11", "test after clear", ok_l, 0);
    cmd(C_LTEST, 12'h011, 0, 0, 4'hF); chk("R11", "no owner after clear", ok_l, 1);
    cmd(C_LSET, 12'h031, 0, 0, 4'h2);  chk("R11", "lock set miss err", err_l, 1);
    cmd(C_LTEST, 12'h031, 0, 0, 4'hF); chk("R11", "lock test miss err", err_l, 1);
    chk("R11", "lock test miss ok", ok_l, 0);
  endtask

  task automatic t_touch;
    cmd(C_PROBE, 12'h000);
    chk("R9", "lru victim set0", addr_l, 12'h01C);
    chk("R10", "plru victim set0", addr_p, 12'h010);
    cmd(C_TOUCH, 12'h01C); chk("R4", "touch hit", ok_l, 1);
    cmd(C_PROBE, 12'h000);
    chk("R4", "lru victim after touch", addr_l, 12'h010);
    chk("R10", "plru victim after touch", addr_p, 12'h010);
    cmd(C_TOUCH, 12'h0F0); chk("R4", "touch miss", ok_l, 0);
    cmd(C_PROBE, 12'h002); chk("R9", "probe not full", ok_l, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_handshake();
    t_fill_and_policy();
    t_avail_errors();
    t_not_present();
    t_dealloc();
    t_access_rules();
    t_locks();
    t_touch();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule